// File: doc/BRIEF.md
# Alternating Dual-Output PWM Generator

This block is a fixed-frequency digital pulse-width modulator with two push-pull outputs. A free-running counter walks through a discharge phase and then a ramp phase. Both lengths are given in system clocks. Each ramp phase carries at most one pulse, and the outputs take turns: one ramp serves output A and the next serves output B. Each output therefore switches at half the ramp frequency. A clock output is high for the whole discharge phase, so the discharge phase is also the dead time between pulses.

A pulse starts on the first clock of the ramp phase and ends at the earliest of three events:
- the ramp count reaching the effective duty command, which is the smaller of the duty code and the soft-start clamp;
- the current-limit flag;
- the overcurrent flag.

A blanking window at the start of each pulse hides the duty compare and the current-limit flag. The overcurrent flag is never hidden. A force-low input masks both outputs, but the alternation keeps running underneath it.

Top module: `alt_pwm_top`

## Requirements
- R1: Within one ramp phase at most one output is high. After reset the first ramp phase serves `out_a_o`, and the served output changes every ramp phase.
- R2: The counter holds `clk_o` high for `dead_len_i` clocks, then low for `ramp_len_i` clocks, repeating. Both outputs are low whenever `clk_o` is high. A length of 0 acts as 1.
- R3: With no flags and an effective duty E of at least `blank_len_i`, the served output is high for the first min(E, `ramp_len_i`) clocks of the ramp phase.
- R4: The effective duty E equals min(`duty_i`, `ss_clamp_i`).
- R5: During the first `blank_len_i` clocks of the ramp phase, the duty compare and `ilim_i` are ignored. The pulse width is therefore min(`ramp_len_i`, max(E, `blank_len_i`)) when E is nonzero.
- R6: `ilim_i` high after the blanking window drives the served output low in the same clock. The output stays low for the rest of that ramp phase.
- R7: `ocp_i` high drives both outputs low in the same clock, including inside the blanking window. The pulse stays off for the rest of that ramp phase.
- R8: If E is 0 when the ramp phase starts, that ramp phase has no pulse, whatever `blank_len_i` is.
- R9: `force_low_i` holds both outputs low. The served output still changes every ramp phase while it is high.
- R10: While `rst_ni` is low, both outputs are low and `clk_o` is high. After release, the discharge phase runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ramp_len_i | input | CW | Ramp phase length in clocks |
| dead_len_i | input | CW | Discharge (dead-time) length in clocks |
| blank_len_i | input | CW | Leading-edge blanking length in clocks |
| duty_i | input | CW | Duty command in ramp clocks |
| ss_clamp_i | input | CW | Soft-start duty clamp |
| ilim_i | input | 1 | Current-limit flag (blanked) |
| ocp_i | input | 1 | Overcurrent flag (never blanked) |
| force_low_i | input | 1 | Holds both outputs low |
| out_a_o | output | 1 | Output A |
| out_b_o | output | 1 | Output B |
| clk_o | output | 1 | High during discharge phase |

## Verification
The hardest situation to reach from the ports is an overcurrent flag arriving in the middle of a pulse that is still inside its blanking window. The bench finds the rising edge of output A by watching it at falling clock edges. It counts two ramp clocks into the pulse, raises `ocp_i` for one clock, and checks that the output drops at once and stays low until the ramp ends. A second hard case is alternation under force-low. It is reached by holding `force_low_i` through the first period and then confirming that the next pulse appears on output B.

// File: rtl/alt_pwm_pkg.sv
package alt_pwm_pkg;
   typedef enum logic {
      PH_DISCH = 1'b0,
      PH_RAMP  = 1'b1
   } phase_e;

   localparam int unsigned NUM_OUTS = 2;
endpackage

// File: rtl/alt_pwm_timer.sv
module alt_pwm_timer
   import alt_pwm_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] ramp_len_i,
   input  logic [CW-1:0] dead_len_i,
   output phase_e        phase_o,
   output logic [CW-1:0] cnt_o,
   output logic          start_o,
   output logic          wrap_o
);
   localparam int unsigned XW = CW + 1;

   phase_e        phase_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_sel;
   logic [XW-1:0] cnt_next;
   logic          last;

   generate
      if (CW < 2) begin : g_bad_width
         $error("alt_pwm_timer: CW must be at least 2");
      end
   endgenerate

   assign len_sel  = (phase_q == PH_DISCH) ? dead_len_i : ramp_len_i;
   assign cnt_next = {1'b0, cnt_q} + XW'(1);
   // a zero length behaves as one clock
   assign last     = cnt_next >= {1'b0, len_sel};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_DISCH;
         cnt_q   <= '0;
      end else if (last) begin
         phase_q <= (phase_q == PH_DISCH) ? PH_RAMP : PH_DISCH;
         cnt_q   <= '0;
      end else begin
         cnt_q   <= cnt_next[CW-1:0];
      end
   end

   assign phase_o = phase_q;
   assign cnt_o   = cnt_q;
   assign start_o = (phase_q == PH_DISCH) && last;
   assign wrap_o  = (phase_q == PH_RAMP) && last;

   AST_PHASE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_o || wrap_o) |=> (phase_q != $past(phase_q)) && (cnt_q == '0)); // R2
endmodule

// File: rtl/alt_pwm_steer.sv
module alt_pwm_steer (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wrap_i,
   output logic sel_o
);
   logic sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sel_q <= 1'b0;
      else if (wrap_i) sel_q <= ~sel_q;
   end

   assign sel_o = sel_q;

   AST_STEER_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_i |=> (sel_o != $past(sel_o))); // R1
   AST_STEER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_i |=> $stable(sel_o)); // R9
endmodule

// File: rtl/alt_pwm_term.sv
module alt_pwm_term
   import alt_pwm_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  phase_e        phase_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          start_i,
   input  logic [CW-1:0] duty_i,
   input  logic [CW-1:0] clamp_i,
   input  logic [CW-1:0] blank_len_i,
   input  logic          ilim_i,
   input  logic          ocp_i,
   output logic          pulse_o
);
   logic [CW-1:0] eff_duty;
   logic          arm_q;
   logic          kill_q;
   logic          in_ramp;
   logic          blanked;
   logic          soft_stop;
   logic          stop_now;

   assign eff_duty  = (duty_i < clamp_i) ? duty_i : clamp_i;
   assign in_ramp   = (phase_i == PH_RAMP);
   assign blanked   = cnt_i < blank_len_i;
   assign soft_stop = !blanked && (ilim_i || (cnt_i >= eff_duty));
   assign stop_now  = ocp_i || soft_stop;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arm_q  <= 1'b0;
         kill_q <= 1'b0;
      end else if (start_i) begin
         arm_q  <= (eff_duty != '0);
         kill_q <= 1'b0;
      end else if (in_ramp && stop_now) begin
         kill_q <= 1'b1;
      end
   end

   assign pulse_o = in_ramp && arm_q && !kill_q && !stop_now;

   AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && (eff_duty == '0)) |=> !pulse_o); // R8
   AST_KILL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_ramp && ocp_i && !start_i) |=> !pulse_o); // R7
   AST_BLANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_o && !ocp_i && (cnt_i + 1'b1 < blank_len_i) && in_ramp && !start_i
       && !$isunknown(cnt_i)) |=> (pulse_o || ocp_i || !in_ramp)); // R5
endmodule

// File: rtl/alt_pwm_top.sv
module alt_pwm_top
   import alt_pwm_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] ramp_len_i,
   input  logic [CW-1:0] dead_len_i,
   input  logic [CW-1:0] blank_len_i,
   input  logic [CW-1:0] duty_i,
   input  logic [CW-1:0] ss_clamp_i,
   input  logic          ilim_i,
   input  logic          ocp_i,
   input  logic          force_low_i,
   output logic          out_a_o,
   output logic          out_b_o,
   output logic          clk_o
);
   phase_e        phase;
   logic [CW-1:0] cnt;
   logic          start;
   logic          wrap;
   logic          sel;
   logic          pulse;
   logic [NUM_OUTS-1:0] outs;

   alt_pwm_timer #(.CW(CW)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ramp_len_i (ramp_len_i),
      .dead_len_i (dead_len_i),
      .phase_o    (phase),
      .cnt_o      (cnt),
      .start_o    (start),
      .wrap_o     (wrap)
   );

   alt_pwm_steer u_steer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wrap_i (wrap),
      .sel_o  (sel)
   );

   alt_pwm_term #(.CW(CW)) u_term (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .phase_i     (phase),
      .cnt_i       (cnt),
      .start_i     (start),
      .duty_i      (duty_i),
      .clamp_i     (ss_clamp_i),
      .blank_len_i (blank_len_i),
      .ilim_i      (ilim_i),
      .ocp_i       (ocp_i),
      .pulse_o     (pulse)
   );

   for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
      assign outs[g] = pulse && !force_low_i && (sel == g[0]);
   end

   assign out_a_o = outs[0];
   assign out_b_o = outs[1];
   assign clk_o   = (phase == PH_DISCH);

   AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(out_a_o && out_b_o)); // R1
   AST_DEAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_o |-> !(out_a_o || out_b_o)); // R2
   AST_OCP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ocp_i |-> !(out_a_o || out_b_o)); // R7
   AST_FORCE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_low_i |-> !(out_a_o || out_b_o)); // R9
endmodule

// File: tb/alt_pwm_top_tb.sv
module alt_pwm_top_tb_top;
   localparam int unsigned CW = 8;

   typedef struct packed {
      logic [7:0] ramp;
      logic [7:0] dead;
      logic [7:0] blank;
      logic [7:0] duty;
      logic [7:0] clamp;
      logic       ilim;
      logic       ocp;
      logic       frc;
      logic [7:0] width;
   } vec_t;

   // expected width: 0 if min(duty,clamp)==0, else min(ramp, max(eff, blank)), masked by flags
   localparam vec_t VECS [10] = '{
      '{8'd20, 8'd4, 8'd3, 8'd8,  8'd255, 1'b0, 1'b0, 1'b0, 8'd8 },  // R3 basic
      '{8'd20, 8'd4, 8'd3, 8'd0,  8'd255, 1'b0, 1'b0, 1'b0, 8'd0 },  // R8 zero duty
      '{8'd20, 8'd4, 8'd3, 8'd30, 8'd255, 1'b0, 1'b0, 1'b0, 8'd20},  // R3 capped at ramp
      '{8'd20, 8'd4, 8'd3, 8'd12, 8'd5,   1'b0, 1'b0, 1'b0, 8'd5 },  // R4 clamp wins
      '{8'd20, 8'd4, 8'd6, 8'd3,  8'd255, 1'b0, 1'b0, 1'b0, 8'd6 },  // R5 blank stretches
      '{8'd20, 8'd4, 8'd6, 8'd12, 8'd255, 1'b1, 1'b0, 1'b0, 8'd6 },  // R6 ilim after blank
      '{8'd20, 8'd4, 8'd6, 8'd12, 8'd255, 1'b0, 1'b1, 1'b0, 8'd0 },  // R7 ocp unblanked
      '{8'd10, 8'd2, 8'd2, 8'd4,  8'd255, 1'b0, 1'b0, 1'b0, 8'd4 },  // R2 other lengths
      '{8'd20, 8'd4, 8'd0, 8'd12, 8'd255, 1'b1, 1'b0, 1'b0, 8'd0 },  // R6 no blanking
      '{8'd20, 8'd4, 8'd3, 8'd8,  8'd255, 1'b0, 1'b0, 1'b1, 8'd0 }   // R9 forced low
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] ramp_len, dead_len, blank_len, duty, clamp;
   logic          ilim, ocp, frc;
   logic          out_a, out_b, clk_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   alt_pwm_top #(.CW(CW)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ramp_len_i  (ramp_len),
      .dead_len_i  (dead_len),
      .blank_len_i (blank_len),
      .duty_i      (duty),
      .ss_clamp_i  (clamp),
      .ilim_i      (ilim),
      .ocp_i       (ocp),
      .force_low_i (frc),
      .out_a_o     (out_a),
      .out_b_o     (out_b),
      .clk_o       (clk_out)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply(vec_t v);
      @(negedge clk);
      rst_n     = 1'b0;
      ramp_len  = v.ramp;
      dead_len  = v.dead;
      blank_len = v.blank;
      duty      = v.duty;
      clamp     = v.clamp;
      ilim      = v.ilim;
      ocp       = v.ocp;
      frc       = v.frc;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   initial begin
      vec_t v;
      // reset state, R10
      ramp_len = 8'd20; dead_len = 8'd4; blank_len = 8'd3; duty = 8'd8;
      clamp = 8'd255; ilim = 1'b0; ocp = 1'b0; frc = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 out_a in reset", out_a, 0);
      check("R10 out_b in reset", out_b, 0);
      check("R10 clk_o in reset", clk_out, 1);

      // vector table
      for (int i = 0; i < 10; i++) begin
         int per, a1, b1, a2, b2, chi, bad_dead;
         v = VECS[i];
         apply(v);
         per = int'(v.dead) + int'(v.ramp);
         a1 = 0; b1 = 0; a2 = 0; b2 = 0; chi = 0; bad_dead = 0;
         for (int k = 0; k < 2 * per; k++) begin
            if (k < per) begin a1 += out_a; b1 += out_b; end
            else         begin a2 += out_a; b2 += out_b; end
            chi += clk_out;
            if (clk_out && (out_a || out_b)) bad_dead++;
            @(negedge clk);
         end
         check($sformatf("R1/R3 vec%0d A width first period", i), a1, v.width);
         check($sformatf("R1 vec%0d B silent first period", i), b1, 0);
         check($sformatf("R1 vec%0d A silent second period", i), a2, 0);
         check($sformatf("R1/R5 vec%0d B width second period", i), b2, v.width);
         check($sformatf("R2 vec%0d clk_o high clocks", i), chi, 2 * int'(v.dead));
         check($sformatf("R2 vec%0d outputs in dead time", i), bad_dead, 0);
      end

      // R7: overcurrent inside blanking window ends pulse at once and for the cycle
      begin
         int guard, late;
         v = '{8'd20, 8'd4, 8'd10, 8'd15, 8'd255, 1'b0, 1'b0, 1'b0, 8'd0};
         apply(v);
         guard = 0;
         while (!out_a && guard < 100) begin @(negedge clk); guard++; end
         check("R3 pulse starts after dead time", guard, 4);
         repeat (2) @(negedge clk);
         check("R5 still high inside blank", out_a, 1);
         ocp = 1'b1;
         #1;
         check("R7 ocp drops output same clock", out_a, 0);
         @(negedge clk);
         ocp = 1'b0;
         late = 0;
         for (int k = 0; k < 17; k++) begin
            late += out_a;
            @(negedge clk);
         end
         check("R7 output stays off rest of ramp", late, 0);
      end

      // R6: current limit after blanking drops the output in the same clock
      begin
         int guard, late;
         v = '{8'd20, 8'd4, 8'd2, 8'd15, 8'd255, 1'b0, 1'b0, 1'b0, 8'd0};
         apply(v);
         guard = 0;
         while (!out_a && guard < 100) begin @(negedge clk); guard++; end
         repeat (5) @(negedge clk);
         check("R6 high before ilim", out_a, 1);
         ilim = 1'b1;
         #1;
         check("R6 ilim drops output same clock", out_a, 0);
         @(negedge clk);
         ilim = 1'b0;
         late = 0;
         for (int k = 0; k < 13; k++) begin
            late += out_a;
            @(negedge clk);
         end
         check("R6 output stays off rest of ramp", late, 0);
      end

      // R9: steering keeps running under force-low
      begin
         int a, b;
         v = '{8'd20, 8'd4, 8'd3, 8'd8, 8'd255, 1'b0, 1'b0, 1'b1, 8'd0};
         apply(v);
         a = 0; b = 0;
         for (int k = 0; k < 24; k++) begin
            a += out_a; b += out_b;
            @(negedge clk);
         end
         check("R9 forced period A", a, 0);
         check("R9 forced period B", b, 0);
         frc = 1'b0;
         a = 0; b = 0;
         for (int k = 0; k < 24; k++) begin
            a += out_a; b += out_b;
            @(negedge clk);
         end
         check("R9 after release A silent", a, 0);
         check("R9 after release B serves", b, 8);
      end

      finish_run();
   end
endmodule